// File: doc/BRIEF.md
# Per-Hart External Interrupt Gate

This block is the delivery stage for one hart of a wired interrupt controller. Elsewhere, per-source logic keeps the pending and enable bits and the per-source target words. This block takes all of them in. It picks the most urgent source that is eligible for its hart, drives the hart's external interrupt line, and provides a small window of control registers on a simple 32-bit register bus. The window holds delivery enable, force, threshold, a read-only top-interrupt word and a claim word.

Software handles interrupts by reading the claim word until it returns zero. Each claim read reports the current winner. In the same cycle, the block sends a one-cycle clear pulse back to the pending logic for that source. Source numbers start at 1, and the value 0 means "no interrupt". The hart index of the block is a parameter, and the block decodes only its own 32-byte window.

Top module: `hart_irq_gate`

## Requirements
- R1: After reset, delivery enable, force and threshold read as 0, `irq_o` is low and `clr_o` is all zero.
- R2: The register window starts at byte address 0x4000 + 32*HART_ID. The offsets are: delivery enable 0x00 (bit 0), force 0x04 (bit 0), threshold 0x08 (bits 7:0), top-interrupt 0x18 and claim 0x1C. Writes outside the window change nothing, and reads of unmapped addresses return 0.
- R3: Source k is bit k-1 of `pend_i`, `en_i` and `clr_o`. Its 32-bit target word is `tgt_i[32*(k-1) +: 32]`, with the hart index in bits 31:18 and the priority in bits 7:0. A source is a candidate only if it is pending, enabled, and its hart index equals HART_ID.
- R4: When the threshold is nonzero, a candidate is eligible only if its priority is strictly less than the threshold. A threshold of 0 lets every candidate through.
- R5: A lower priority number wins. On equal priority, the lower source number wins. A priority field of 0 counts as priority 1.
- R6: The top-interrupt word holds the winner's source number in bits 25:16 and its priority in bits 7:0. It reads 0 when no source is eligible. Reading it changes no state.
- R7: A claim read returns the same word as the top-interrupt register. In the cycle of the read it pulses the winner's bit of `clr_o` and no other bit. When nothing is eligible it returns 0 and pulses nothing.
- R8: `irq_o` is high exactly when (the top-interrupt word is nonzero and delivery enable is 1) or force is 1.
- R9: Read data appears on `bus_rdata` with `bus_rvalid` high one cycle after the read access. `bus_rvalid` is low in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | NSRC | Pending bit per source (bit k-1 = source k) |
| en_i | input | NSRC | Enable bit per source |
| tgt_i | input | 32*NSRC | Target words: hart index 31:18, priority 7:0 |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_rvalid | output | 1 | Read data valid |
| clr_o | output | NSRC | One-cycle pending-clear pulse on a claim |
| irq_o | output | 1 | External interrupt line to the hart |

## Verification
Assertions check the following on every cycle. The clear pulse is at most one-hot, appears only during a claim read of this window, and only ever hits a source that is pending and enabled. Force always raises the line. Any reported winner lies under a nonzero threshold. Read responses follow reads by one cycle.

Only the bench's scenarios can show the rest. Those are the choice of winner under ties, zero priorities and foreign hart indices, the exact word layout, the claim-until-zero sequence, and the fact that top-interrupt reads and writes to another hart's window leave state untouched.

// File: rtl/hart_irq_gate.sv
module hart_irq_gate #(
  parameter int NSRC    = 16,
  parameter int HART_ID = 0,
  parameter int ADDR_W  = 20,
  parameter int HIDX_W  = 14,
  parameter int PRIO_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      pend_i,
  input  logic [NSRC-1:0]      en_i,
  input  logic [32*NSRC-1:0]   tgt_i,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  output logic [NSRC-1:0]      clr_o,
  output logic                 irq_o
);
  localparam int ID_W = 10;
  localparam int HIDX_LSB = 18;
  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(32'h4000 + HART_ID * 32);
  localparam logic [HIDX_W-1:0] MY_HART = HIDX_W'(HART_ID);
  localparam logic [4:0] OFF_DELIV = 5'h00;
  localparam logic [4:0] OFF_FORCE = 5'h04;
  localparam logic [4:0] OFF_THR   = 5'h08;
  localparam logic [4:0] OFF_TOP   = 5'h18;
  localparam logic [4:0] OFF_CLAIM = 5'h1C;

  logic              deliv_q, force_q;
  logic [PRIO_W-1:0] thr_q;
  logic              found;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_pr;
  logic [31:0]       top_word;

  wire       win_hit  = bus_sel && (bus_addr[ADDR_W-1:5] == WIN_BASE[ADDR_W-1:5]);
  wire [4:0] off      = bus_addr[4:0];
  wire       rd_claim = win_hit && !bus_wr && (off == OFF_CLAIM);

  always_comb begin
    logic [PRIO_W-1:0] pr;
    logic [HIDX_W-1:0] hid;
    logic              ok;
    found   = 1'b0;
    best_id = '0;
    best_pr = '0;
    for (int k = 0; k < NSRC; k++) begin
      pr  = tgt_i[32*k +: PRIO_W];
      if (pr == '0) pr = PRIO_W'(1);
      hid = tgt_i[32*k+HIDX_LSB +: HIDX_W];
      ok  = pend_i[k] && en_i[k] && (hid == MY_HART) &&
            ((thr_q == '0) || (pr < thr_q));
      if (ok && (!found || pr < best_pr)) begin
        found   = 1'b1;
        best_id = ID_W'(k + 1);
        best_pr = pr;
      end
    end
  end

  assign top_word = found ? ((32'(best_id) << 16) | 32'(best_pr)) : 32'd0;
  assign clr_o    = (rd_claim && found) ? (NSRC'(1) << (best_id - ID_W'(1))) : '0;
  assign irq_o    = ((top_word != 32'd0) && deliv_q) || force_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deliv_q <= 1'b0;
      force_q <= 1'b0;
      thr_q   <= '0;
    end else if (win_hit && bus_wr) begin
      case (off)
        OFF_DELIV: deliv_q <= bus_wdata[0];
        OFF_FORCE: force_q <= bus_wdata[0];
        OFF_THR:   thr_q   <= bus_wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= 32'd0;
    end else begin
      bus_rvalid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) begin
        if (!win_hit) bus_rdata <= 32'd0;
        else begin
          case (off)
            OFF_DELIV: bus_rdata <= {31'd0, deliv_q};
            OFF_FORCE: bus_rdata <= {31'd0, force_q};
            OFF_THR:   bus_rdata <= 32'(thr_q);
            OFF_TOP,
            OFF_CLAIM: bus_rdata <= top_word;
            default:   bus_rdata <= 32'd0;
          endcase
        end
      end
    end
  end

  // R7
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(clr_o));
  // R7
  clr_needs_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |-> (bus_sel && !bus_wr && bus_addr[4:0] == OFF_CLAIM));
  // R3
  clr_live_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o & ~(pend_i & en_i)) == '0);
  // R8
  force_irq_chk: assert property (@(posedge clk) disable iff (!rst_n) force_q |-> irq_o);
  // R4
  thr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q != '0 && top_word != 32'd0) |-> (top_word[PRIO_W-1:0] < thr_q));
  // R9
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);
endmodule

// File: tb/sim_hart_irq_gate.sv
`timescale 1ns/1ps
module sim_hart_irq_gate;
  localparam int NSRC = 16;
  localparam int AW = 20;
  localparam logic [AW-1:0] WB = 20'h04000;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] pend_set = '0, cleared, en_i = '1;
  logic clr_rst = 1;
  logic [32*NSRC-1:0] tgt_i;
  logic bus_sel = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, irq_o;
  logic [NSRC-1:0] clr_o;
  wire [NSRC-1:0] pend_i = pend_set & ~cleared;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk)
    if (clr_rst) cleared <= '0; else cleared <= cleared | clr_o;

  hart_irq_gate #(.NSRC(NSRC), .HART_ID(0), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i), .tgt_i(tgt_i),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .clr_o(clr_o), .irq_o(irq_o));

  function automatic logic [31:0] tgt_of(int k);
    logic [7:0] p;
    logic [13:0] h;
    h = (k == 5) ? 14'd3 : 14'd0;
    case (k)
      1: p = 7; 2: p = 3; 3: p = 3; 4: p = 0; 5: p = 1; 6: p = 9;
      default: p = 8'(20 + k);
    endcase
    return {h, 10'd0, p};
  endfunction

  // pend[55:40] thr[39:32] expected top word[31:0]
  localparam logic [55:0] VEC [10] = '{
    {16'h0001, 8'd0,  32'h0001_0007},
    {16'h0006, 8'd0,  32'h0002_0003},
    {16'h000F, 8'd0,  32'h0004_0001},
    {16'h0010, 8'd0,  32'h0000_0000},
    {16'h0023, 8'd3,  32'h0000_0000},
    {16'h0023, 8'd4,  32'h0002_0003},
    {16'h8000, 8'd36, 32'h0000_0000},
    {16'h8000, 8'd37, 32'h0010_0024},
    {16'h0041, 8'd0,  32'h0001_0007},
    {16'h0000, 8'd0,  32'h0000_0000}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
    d = bus_rdata;
    chk("R9 rvalid", 32'(bus_rvalid), 32'd1);
  endtask

  task automatic set_pend(logic [NSRC-1:0] v);
    @(negedge clk); pend_set = v; clr_rst = 1;
    @(negedge clk); clr_rst = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int k = 1; k <= NSRC; k++) tgt_i[32*(k-1) +: 32] = tgt_of(k);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 clr", 32'(clr_o), 0);
    rd(WB + 0, d); chk("R1 deliv", d, 0);
    rd(WB + 4, d); chk("R1 force", d, 0);
    rd(WB + 8, d); chk("R1 thr", d, 0);
    @(negedge clk); chk("R9 rvalid idle", 32'(bus_rvalid), 0);
    // R2 writes in and out of window
    wr(WB + 0, 32'd1);
    rd(WB + 0, d); chk("R2 deliv", d, 1);
    wr(WB + 32 + 8, 32'd5);
    rd(WB + 8, d); chk("R2 foreign thr", d, 0);
    rd(WB + 32'h10, d); chk("R2 unmapped", d, 0);
    // table: R3 R4 R5 R6 R8
    for (int i = 0; i < 10; i++) begin
      set_pend(VEC[i][55:40]);
      wr(WB + 8, 32'(VEC[i][39:32]));
      rd(WB + 8'h18, d); chk("R4/R5 table top", d, VEC[i][31:0]);
      chk("R8 table irq", 32'(irq_o), 32'(VEC[i][31:0] != 0));
    end
    wr(WB + 8, 32'd0);
    // R8 delivery off
    wr(WB + 0, 32'd0);
    set_pend(16'h0001);
    chk("R8 deliv off irq", 32'(irq_o), 0);
    rd(WB + 8'h18, d); chk("R6 top while off", d, 32'h0001_0007);
    // R8 force
    set_pend(16'h0000);
    wr(WB + 4, 32'd1);
    chk("R8 force irq", 32'(irq_o), 1);
    wr(WB + 4, 32'd0);
    chk("R8 force off irq", 32'(irq_o), 0);
    wr(WB + 0, 32'd1);
    // R3 per-source enable
    set_pend(16'h0006);
    @(negedge clk); en_i = ~16'h0002;
    rd(WB + 8'h18, d); chk("R3 enable mask", d, 32'h0003_0003);
    @(negedge clk); en_i = '1;
    // R6 top read has no side effect
    rd(WB + 8'h18, d); chk("R6 top first", d, 32'h0002_0003);
    rd(WB + 8'h18, d); chk("R6 top second", d, 32'h0002_0003);
    chk("R6 pend kept", 32'(pend_i), 32'h0006);
    // R7 claim loop
    rd(WB + 8'h1C, d); chk("R7 claim1", d, 32'h0002_0003);
    chk("R7 cleared2", 32'(pend_i), 32'h0004);
    rd(WB + 8'h1C, d); chk("R7 claim2", d, 32'h0003_0003);
    chk("R7 cleared3", 32'(pend_i), 32'h0000);
    rd(WB + 8'h1C, d); chk("R7 claim empty", d, 0);
    chk("R8 idle irq", 32'(irq_o), 0);
    // R7 claim skips foreign hart source
    set_pend(16'h0010);
    rd(WB + 8'h1C, d); chk("R7 claim foreign", d, 0);
    chk("R7 foreign kept", 32'(pend_i), 32'h0010);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule